// File: doc/BRIEF.md
# Atomic Bit-Manipulation Bus Bridge

This bridge is placed in series on a 32-bit AHB-style path, between an upstream crossbar slave port and a downstream peripheral bridge. Ordinary transfers cross it with no added wait state. The upstream address and control reach the downstream port in the same cycle, and the downstream data-phase answer (read data, ready, error) returns upstream in the same cycle.

Some upstream accesses carry a marker in their upper address bits. The bridge turns each of these into a locked pair of downstream transfers: a read of the peripheral word, then a write of a computed value to the same address. Upstream ready stays low until that pair is complete. Decorated loads can return an unsigned bit field, or return one bit and then set or clear that bit in the peripheral. Decorated stores can insert a field, or combine the write data with the current contents by AND, OR or XOR. Byte, halfword and word sizes are accepted.

Both ports use AHB timing. An address phase is taken on a rising edge where request and ready are both high. The data phase that follows ends on the next edge where ready is high. Upstream back-pressure is the ready output alone: the master must hold its write data steady while ready is low. The bridge waits on downstream ready in each phase of its read/write pair. Errors are one-cycle responses given together with ready.

Top module: `atomic_bitop_bridge`

## Requirements
- R1: A non-decorated address phase is forwarded downstream unchanged in the same cycle. For such a transfer, up_ready, up_rdata and up_err follow dn_ready, dn_rdata and dn_err, so with a ready downstream the upstream data phase has zero wait cycles.
- R2: An access is decorated when addr[31:29] equals the tag (default 3'b010) and the code in addr[28:26] is not zero. The codes are 1 AND, 2 OR, 3 XOR, 4 field insert (these four are stores), 5 field extract, 6 read-and-clear bit, 7 read-and-set bit (these three are loads). Any other address is plain.
- R3: The downstream address of a decorated access clears bits [28:15] for codes 4 to 7 and bits [28:26] for codes 1 to 3. All other address bits are kept, including the low two bits.
- R4: A decorated access that writes issues a downstream read, then a downstream write to the same address. With a zero-wait downstream the upstream data phase holds up_ready low for exactly 4 cycles.
- R5: Extract (code 5) returns (old & fmask & lanes) >> pos, with pos = addr[23:19], width = addr[18:15] + 1 and fmask = ((1 << width) - 1) << pos. It writes nothing, and it stalls 2 cycles with a zero-wait downstream.
- R6: Codes 6 and 7 return the old value of bit pos in bit 0 of up_rdata. They write back the word with that bit cleared (code 6) or set (code 7), but only if the bit lies in an active lane.
- R7: Insert (code 4) writes (old & ~m) | ((wdata << pos) & m), where m = fmask & lanes. The field value is taken from the low bits of the write data.
- R8: Codes 1, 2 and 3 write old AND, OR or XOR wdata within the active lanes. Bytes outside the active lanes are left unchanged.
- R9: Size codes are 0 byte, 1 halfword, 2 word. The active lanes are byte addr[1:0] for size 0, halfword addr[1] for size 1, and all four bytes for size 2. The size is forwarded downstream on both transfers of a pair.
- R10: An error on the downstream read of a pair ends it with up_err and up_ready high, and no downstream write is issued.
- R11: An error on the downstream write of a pair is returned upstream as up_err together with up_ready.
- R12: A decorated access whose direction does not match its code (a read with codes 1 to 4, or a write with codes 5 to 7) causes no downstream transfer. It answers with up_err in its first data-phase cycle.
- R13: While dn_valid is low, dn_addr, dn_write and dn_size keep the values they last carried.
- R14: Each downstream wait cycle in either phase of a pair adds exactly one upstream stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Upstream address phase present |
| up_addr | input | 32 | Upstream address, including the decoration |
| up_write | input | 1 | Upstream transfer is a write |
| up_size | input | 2 | Upstream transfer size |
| up_wdata | input | 32 | Upstream write data (data phase) |
| up_rdata | output | 32 | Upstream read data |
| up_ready | output | 1 | Upstream ready; low stalls the master |
| up_err | output | 1 | Upstream error response |
| dn_valid | output | 1 | Downstream address phase present |
| dn_addr | output | 32 | Downstream address |
| dn_write | output | 1 | Downstream transfer is a write |
| dn_size | output | 2 | Downstream transfer size |
| dn_wdata | output | 32 | Downstream write data (data phase) |
| dn_rdata | input | 32 | Downstream read data |
| dn_ready | input | 1 | Downstream ready |
| dn_err | input | 1 | Downstream error response |

## Verification
The bench counts how many cycles up_ready stays low in each upstream data phase and checks that count for every access. With a zero-wait downstream the count must be 0 for plain and mismatched accesses, 2 for an extract or a read-side error, and 4 for a full read/write pair. With two wait cycles per downstream phase it must be 2 for plain, 4 for an extract and 8 for a pair. Every returned value is sampled at the falling edge of the cycle in which up_ready is high, and downstream effects are confirmed by a plain read-back after the pair has finished.

// File: rtl/abb_pkg.sv
package abb_pkg;
  localparam int DW       = 32;
  localparam int AW       = 32;
  localparam int TAG_LSB  = 29;
  localparam int OP_LSB   = 26;
  localparam int POS_LSB  = 19;
  localparam int POS_W    = 5;
  localparam int WID_LSB  = 15;
  localparam int WID_W    = 4;
  localparam int FLD_W    = WID_W + 1;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_AND = 3'd1, OP_OR = 3'd2, OP_XOR = 3'd3,
    OP_INS  = 3'd4, OP_EXT = 3'd5, OP_LCLR = 3'd6, OP_LSET = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RDA, S_RDD, S_WRA, S_WRD, S_DONE, S_ERR
  } st_e;
endpackage

// File: rtl/abb_decode.sv
module abb_decode import abb_pkg::*; #(
  parameter logic [2:0] TAG = 3'b010
) (
  input  logic [AW-1:0]    addr,
  input  logic             wr,
  output logic             dec,
  output op_e              op,
  output logic             bad_dir,
  output logic             need_wr,
  output logic [AW-1:0]    clean,
  output logic [POS_W-1:0] pos,
  output logic [FLD_W-1:0] wid
);
  logic store_op;

  always_comb begin
    op       = op_e'(addr[OP_LSB +: 3]);
    dec      = (addr[TAG_LSB +: 3] == TAG) && (op != OP_NONE);
    store_op = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_INS);
    bad_dir  = dec && (wr != store_op);
    need_wr  = (op != OP_EXT);
    pos      = addr[POS_LSB +: POS_W];
    wid      = {1'b0, addr[WID_LSB +: WID_W]} + FLD_W'(1);
    clean    = addr;
    if (op == OP_INS || op == OP_EXT || op == OP_LCLR || op == OP_LSET)
      clean[TAG_LSB-1:WID_LSB] = '0;
    else
      clean[TAG_LSB-1:OP_LSB] = '0;
  end

  // R3: decoration code never reaches the downstream address
  always_comb begin
    if (dec) p_clean_code_r3: assert (clean[TAG_LSB-1:OP_LSB] == 3'd0);
  end
endmodule

// File: rtl/abb_alu.sv
module abb_alu import abb_pkg::*; (
  input  op_e              op,
  input  logic [POS_W-1:0] pos,
  input  logic [FLD_W-1:0] wid,
  input  logic [1:0]       size,
  input  logic [1:0]       off,
  input  logic [DW-1:0]    old,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    new_word,
  output logic [DW-1:0]    ld_res
);
  logic [DW-1:0] lanes, fmask, fm, bm;

  always_comb begin
    case (size)
      2'd0:    lanes = DW'(32'h0000_00FF) << {off, 3'b000};
      2'd1:    lanes = DW'(32'h0000_FFFF) << {off[1], 4'b0000};
      default: lanes = '1;
    endcase
    fmask = ((DW'(1) << wid) - DW'(1)) << pos;
    fm    = fmask & lanes;
    bm    = (DW'(1) << pos) & lanes;
    ld_res = '0;
    case (op)
      OP_AND:  new_word = old & (wdata | ~lanes);
      OP_OR:   new_word = old | (wdata & lanes);
      OP_XOR:  new_word = old ^ (wdata & lanes);
      OP_INS:  new_word = (old & ~fm) | ((wdata << pos) & fm);
      OP_LCLR: begin new_word = old & ~bm; ld_res = {{(DW-1){1'b0}}, old[pos]}; end
      OP_LSET: begin new_word = old | bm;  ld_res = {{(DW-1){1'b0}}, old[pos]}; end
      OP_EXT:  begin new_word = old;       ld_res = (old & fm) >> pos; end
      default: new_word = old;
    endcase
  end

  // R5: an extracted field never spills above its width
  always_comb begin
    if (op == OP_EXT) p_ext_width_r5: assert ((ld_res >> wid) == '0);
  end
endmodule

// File: rtl/atomic_bitop_bridge.sv
module atomic_bitop_bridge import abb_pkg::*; #(
  parameter logic [2:0] DEC_TAG = 3'b010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_req,
  input  logic [31:0]   up_addr,
  input  logic          up_write,
  input  logic [1:0]    up_size,
  input  logic [31:0]   up_wdata,
  output logic [31:0]   up_rdata,
  output logic          up_ready,
  output logic          up_err,
  output logic          dn_valid,
  output logic [31:0]   dn_addr,
  output logic          dn_write,
  output logic [1:0]    dn_size,
  output logic [31:0]   dn_wdata,
  input  logic [31:0]   dn_rdata,
  input  logic          dn_ready,
  input  logic          dn_err
);
  st_e              st, nxt;
  logic             dec, bad_dir, need_wr, accept, pass;
  op_e              op, op_q;
  logic [AW-1:0]    clean, caddr_q, hold_addr;
  logic [POS_W-1:0] pos, pos_q;
  logic [FLD_W-1:0] wid, wid_q;
  logic [1:0]       size_q, off_q, hold_size;
  logic             need_q, hold_wr;
  logic [DW-1:0]    wd_q, rd_q, new_word, ld_res;

  abb_decode #(.TAG(DEC_TAG)) u_dec (
    .addr(up_addr), .wr(up_write), .dec(dec), .op(op), .bad_dir(bad_dir),
    .need_wr(need_wr), .clean(clean), .pos(pos), .wid(wid)
  );

  abb_alu u_alu (
    .op(op_q), .pos(pos_q), .wid(wid_q), .size(size_q), .off(off_q),
    .old(rd_q), .wdata(wd_q), .new_word(new_word), .ld_res(ld_res)
  );

  // Output steering: open states pass plain traffic, busy states own the bus
  always_comb begin
    dn_valid = 1'b0;
    dn_addr  = hold_addr;
    dn_write = hold_wr;
    dn_size  = hold_size;
    dn_wdata = up_wdata;
    up_ready = 1'b0;
    up_rdata = '0;
    up_err   = 1'b0;
    case (st)
      S_IDLE: begin up_ready = dn_ready; up_rdata = dn_rdata; up_err = dn_err; end
      S_DONE: begin up_ready = 1'b1; up_rdata = ld_res; end
      S_ERR:  begin up_ready = 1'b1; up_err = 1'b1; end
      S_RDA:  begin dn_valid = 1'b1; dn_addr = caddr_q; dn_write = 1'b0; dn_size = size_q; end
      S_WRA:  begin dn_valid = 1'b1; dn_addr = caddr_q; dn_write = 1'b1; dn_size = size_q; end
      S_WRD:  dn_wdata = new_word;
      default: ;
    endcase
    pass = (st == S_IDLE || st == S_DONE || st == S_ERR) && up_req && !dec;
    if (pass) begin
      dn_valid = 1'b1;
      dn_addr  = up_addr;
      dn_write = up_write;
      dn_size  = up_size;
    end
    accept = up_req && up_ready;
  end

  always_comb begin
    nxt = st;
    case (st)
      S_RDA: if (dn_ready) nxt = S_RDD;
      S_RDD: if (dn_ready) nxt = dn_err ? S_ERR : (need_q ? S_WRA : S_DONE);
      S_WRA: if (dn_ready) nxt = S_WRD;
      S_WRD: if (dn_ready) nxt = dn_err ? S_ERR : S_DONE;
      default: nxt = (accept && dec) ? (bad_dir ? S_ERR : S_RDA) : S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      hold_addr <= '0;
      hold_wr   <= 1'b0;
      hold_size <= '0;
    end else begin
      st <= nxt;
      if (dn_valid) begin
        hold_addr <= dn_addr;
        hold_wr   <= dn_write;
        hold_size <= dn_size;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept && dec) begin
      op_q    <= op;
      pos_q   <= pos;
      wid_q   <= wid;
      size_q  <= up_size;
      off_q   <= up_addr[1:0];
      caddr_q <= clean;
      need_q  <= need_wr;
    end
    if (st == S_RDA) wd_q <= up_wdata;
    if (st == S_RDD && dn_ready) rd_q <= dn_rdata;
  end

  // R4: a valid decorated access stalls the following cycle
  p_dec_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec && !bad_dir) |=> !up_ready);
  // R4: the write half only ever follows the read half
  p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRA) |-> ($past(st) == S_RDD || $past(st) == S_WRA));
  // R10: a read-side error is answered next cycle
  p_rd_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDD && dn_ready && dn_err) |=> (up_err && up_ready));
  // R12: a mismatched access never reaches downstream
  p_bad_dir_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad_dir) |-> (!dn_valid ##1 up_err));
  // R13: idle downstream bus keeps its address
  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_valid |-> $stable(dn_addr));
endmodule

// File: tb/atomic_bitop_bridge_test.sv
`timescale 1ns/1ps
module atomic_bitop_bridge_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic up_req = 1'b0, up_write = 1'b0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic [1:0] up_size = 2'd2;
  logic [31:0] up_rdata, dn_addr, dn_wdata, dn_rdata;
  logic up_ready, up_err, dn_valid, dn_write, dn_ready, dn_err;
  logic [1:0] dn_size;

  always #2.5 clk = ~clk;

  atomic_bitop_bridge uut (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_addr(up_addr), .up_write(up_write),
    .up_size(up_size), .up_wdata(up_wdata), .up_rdata(up_rdata), .up_ready(up_ready),
    .up_err(up_err), .dn_valid(dn_valid), .dn_addr(dn_addr), .dn_write(dn_write),
    .dn_size(dn_size), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ready(dn_ready),
    .dn_err(dn_err)
  );

  int n_cmp = 0, n_bad = 0;

  function automatic logic [31:0] lanes_of(input logic [1:0] sz, input logic [1:0] off);
    logic [31:0] m = '0;
    int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    int first = (sz == 2'd0) ? int'(off) : (sz == 2'd1) ? int'(off & 2'b10) : 0;
    for (int b = 0; b < 4; b++) if (b >= first && b < first + nb) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  // downstream slave model: 16 words, idx 15 errors always, idx 14 errors on writes
  logic [31:0] mem [16];
  logic pend, pw;
  logic [31:0] pa, last_addr, last_rd_addr;
  logic [1:0] ps;
  int wcnt, waits = 0, wr_acc = 0, any_acc = 0;

  assign dn_ready = !pend || (wcnt == 0);
  assign dn_err   = pend && (wcnt == 0) && (pa[5:2] == 4'd15 || (pa[5:2] == 4'd14 && pw));
  assign dn_rdata = (pend && !pw && wcnt == 0) ? mem[pa[5:2]] : 32'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; pw <= 1'b0; pa <= '0; ps <= '0; wcnt <= 0;
      last_addr <= '0; last_rd_addr <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      if (pend && wcnt != 0) wcnt <= wcnt - 1;
      if (pend && wcnt == 0 && pw && !dn_err)
        mem[pa[5:2]] <= (mem[pa[5:2]] & ~lanes_of(ps, pa[1:0])) | (dn_wdata & lanes_of(ps, pa[1:0]));
      if (dn_ready) begin
        pend <= dn_valid;
        if (dn_valid) begin
          pa <= dn_addr; pw <= dn_write; ps <= dn_size; wcnt <= waits;
          any_acc <= any_acc + 1; last_addr <= dn_addr;
          if (dn_write) wr_acc <= wr_acc + 1; else last_rd_addr <= dn_addr;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] a, input logic w, input logic [1:0] sz, input logic [31:0] wd,
                      output logic [31:0] rd, output logic e, output int stall);
    @(negedge clk);
    up_req = 1'b1; up_addr = a; up_write = w; up_size = sz;
    #1;
    while (!up_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    up_req = 1'b0; up_wdata = wd; stall = 0;
    #1;
    while (!up_ready) begin stall++; @(negedge clk); #1; end
    rd = up_rdata; e = up_err;
  endtask

  function automatic logic [31:0] ref_word(input int op, input int pos, input int wm1, input logic [1:0] sz,
      input logic [1:0] off, input logic [31:0] old, input logic [31:0] wd);
    logic [31:0] lm = lanes_of(sz, off), r;
    for (int i = 0; i < 32; i++) begin
      bit inf = (i >= pos) && (i <= pos + wm1);
      r[i] = old[i];
      if (lm[i]) begin
        case (op)
          1: r[i] = old[i] & wd[i];
          2: r[i] = old[i] | wd[i];
          3: r[i] = old[i] ^ wd[i];
          4: if (inf) r[i] = wd[i-pos];
          6: if (i == pos) r[i] = 1'b0;
          7: if (i == pos) r[i] = 1'b1;
          default: ;
        endcase
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_ret(input int op, input int pos, input int wm1, input logic [1:0] sz,
      input logic [1:0] off, input logic [31:0] old);
    logic [31:0] lm = lanes_of(sz, off), r = '0;
    if (op == 5) begin
      for (int i = 0; i < 32; i++) if (i >= pos && i <= pos + wm1 && lm[i]) r[i-pos] = old[i];
    end else if (op >= 6) r[0] = old[pos];
    return r;
  endfunction

  function automatic logic [31:0] daddr(input int op, input int pos, input int wm1, input int idx, input int off);
    return 32'h4000_0000 | (32'(op) << 26) | (32'(pos) << 19) | (32'(wm1) << 15) | 32'(idx*4 + off);
  endfunction

  function automatic string tag_of(input int op, input logic [1:0] sz);
    if (sz != 2'd2) return "R9";
    if (op <= 3) return "R8";
    if (op == 4) return "R7";
    if (op == 5) return "R5";
    return "R6";
  endfunction

  initial begin
    repeat (15000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, old, wd, base, exp;
    logic e;
    int st, it, acc0;
    int plist [4] = '{0, 5, 12, 29};
    int wlist [4] = '{0, 3, 7, 15};
    logic [1:0] szl [5] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2};
    logic [1:0] ofl [5] = '{2'd0, 2'd3, 2'd0, 2'd2, 2'd0};

    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset up_ready", {31'b0, up_ready}, 32'd1);
    chk("R1", "reset dn_valid", {31'b0, dn_valid}, 32'd0);
    chk("R1", "reset up_err", {31'b0, up_err}, 32'd0);

    // plain pass-through
    xfer(32'h4000_0010, 1'b1, 2'd2, 32'hDEAD_BEEF, rd, e, st);
    chk("R1", "plain write stall", st, 0);
    xfer(32'h4000_0010, 1'b0, 2'd2, 0, rd, e, st);
    chk("R1", "plain read data", rd, 32'hDEAD_BEEF);
    chk("R1", "plain read stall", st, 0);
    xfer(32'h4000_0011, 1'b1, 2'd0, 32'h0000_5500, rd, e, st);
    xfer(32'h4000_0010, 1'b0, 2'd2, 0, rd, e, st);
    chk("R9", "plain byte lane write", rd, 32'hDEAD_55EF);
    // tag mismatch stays plain
    xfer(32'h6400_0010, 1'b0, 2'd2, 0, rd, e, st);
    chk("R2", "untagged address forwarded", last_addr, 32'h6400_0010);
    chk("R2", "untagged stall", st, 0);

    // sweep of codes, sizes, lanes, positions and widths
    it = 0;
    for (int c = 0; c < 5; c++)
      for (int op = 1; op <= 7; op++)
        for (int p = 0; p < 4; p++)
          for (int w = 0; w < 4; w++) begin
            if (op <= 3 && (p != 0 || w != 0)) continue;
            base = 32'h4000_0000 + 32'((it % 12) * 4);
            old  = 32'h5A3C_96E1 ^ (32'(it) * 32'h9E37_79B9);
            wd   = {old[15:0], old[31:16]} ^ 32'h0F0F_3355 ^ 32'(it);
            xfer(base, 1'b1, 2'd2, old, rd, e, st);
            acc0 = wr_acc;
            xfer(daddr(op, plist[p], wlist[w], it % 12, int'(ofl[c])), (op <= 4), szl[c], wd, rd, e, st);
            chk("R4", "decorated stall", st, (op == 5) ? 2 : 4);
            chk("R4", "decorated err", {31'b0, e}, 0);
            chk("R3", "cleaned read address", last_rd_addr, base + 32'(ofl[c]));
            if (op >= 5)
              chk(tag_of(op, szl[c]), "load result", rd,
                  ref_ret(op, plist[p], wlist[w], szl[c], ofl[c], old));
            if (op == 5) chk("R5", "extract writes nothing", wr_acc, acc0);
            xfer(base, 1'b0, 2'd2, 0, rd, e, st);
            exp = ref_word(op, plist[p], wlist[w], szl[c], ofl[c], old, wd);
            chk(tag_of(op, szl[c]), "word after op", rd, exp);
            it++;
          end

    // logic op keeps address bits below the code
    xfer(32'h4000_0020, 1'b1, 2'd2, 32'h0, rd, e, st);
    xfer(32'h4810_0020, 1'b1, 2'd2, 32'h8000_0001, rd, e, st);
    chk("R3", "logic op address keeps bit 20", last_rd_addr, 32'h4010_0020);

    // downstream wait states
    waits = 2;
    xfer(32'h4000_000C, 1'b1, 2'd2, 32'h0000_00F0, rd, e, st);
    xfer(daddr(2, 0, 0, 3, 0), 1'b1, 2'd2, 32'h0000_0F00, rd, e, st);
    chk("R14", "pair stall with waits", st, 8);
    xfer(daddr(5, 4, 7, 3, 0), 1'b0, 2'd2, 0, rd, e, st);
    chk("R14", "extract stall with waits", st, 4);
    chk("R14", "extract with waits", rd, 32'h0000_00FF);
    xfer(32'h4000_000C, 1'b0, 2'd2, 0, rd, e, st);
    chk("R14", "plain stall with waits", st, 2);
    chk("R14", "word after waited OR", rd, 32'h0000_0FF0);
    waits = 0;

    // read-side error cancels write
    acc0 = wr_acc;
    xfer(daddr(2, 0, 0, 15, 0), 1'b1, 2'd2, 32'hFFFF_FFFF, rd, e, st);
    chk("R10", "read error flagged", {31'b0, e}, 1);
    chk("R10", "read error stall", st, 2);
    chk("R10", "no write after read error", wr_acc, acc0);

    // write-side error
    xfer(daddr(3, 0, 0, 14, 0), 1'b1, 2'd2, 32'h1234_5678, rd, e, st);
    chk("R11", "write error flagged", {31'b0, e}, 1);
    chk("R11", "write error stall", st, 4);
    xfer(32'h4000_0038, 1'b0, 2'd2, 0, rd, e, st);
    chk("R11", "word unchanged after write error", rd, 32'h0);

    // direction mismatch
    acc0 = any_acc;
    xfer(daddr(1, 0, 0, 2, 0), 1'b0, 2'd2, 0, rd, e, st);
    chk("R12", "read with store code err", {31'b0, e}, 1);
    chk("R12", "mismatch stall", st, 0);
    xfer(daddr(5, 0, 3, 2, 0), 1'b1, 2'd2, 32'hFFFF_FFFF, rd, e, st);
    chk("R12", "write with load code err", {31'b0, e}, 1);
    chk("R12", "no downstream transfer", any_acc, acc0);

    // idle hold
    xfer(32'h4000_0014, 1'b0, 2'd1, 0, rd, e, st);
    repeat (3) @(negedge clk);
    #1;
    chk("R13", "idle dn_valid", {31'b0, dn_valid}, 0);
    chk("R13", "idle address held", dn_addr, 32'h4000_0014);
    chk("R13", "idle size held", {30'b0, dn_size}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule